// File: doc/BRIEF.md
# Three-Wire Control Bus Register Slave

This block connects a bank of 16-bit control registers to a three-wire serial control bus made of a data line, a bit clock and a mode line. When the mode line is low the bus master sends one select byte, least significant bit first. That byte carries a two-bit transfer code and a six-bit device identity. When the mode line is high the master sends register and data bytes, or the slave returns them. A write moves one register address and one 16-bit value. A read takes two transactions: a prepare step names the register, and a later select with the read code makes the slave return the address, a validity flag and the value.

All three bus lines are sampled by the system clock through synchronizers, so the bus clock may be slow and asynchronous to it. On the register side the slave issues single-cycle write and read strobes. The register bank answers a read strobe one cycle later with data and a hit flag.

Top module: `l3_slave`

## Requirements
- R1: After reset the slave ignores the bus until one rising edge of the bus clock has woken it. That waking pulse carries no bit, and the slave never drives the data line before it.
- R2: A select byte arrives with the mode line low, first bit in time as bit 0. Bits [1:0] are the transfer code. Bit 2 must equal dev_sel[0] and bit 3 must equal dev_sel[1]. Bits [7:4] must be 4'b0001. A select byte whose identity does not match deselects the slave, and the transfer that follows it has no effect.
- R3: Code bits [1:0] = 2'b10 select write/prepare. A register byte whose first bit is 0, followed by the address bits from A6 down to A0, and then two data bytes (D15 first, then D7 first), produces exactly one reg_wr pulse carrying that address and value.
- R4: Once a write is complete, any further bytes in the same mode-high phase are ignored until a new select byte arrives.
- R5: The bit counter restarts at every mode-line edge. A byte cut short by a mode edge before its eighth clock is discarded.
- R6: A register byte whose first bit is 1 (prepare read) records the address and makes no register access.
- R7: Code 2'b11 after a prepare gives one reg_rd pulse at the prepared address. In the following mode-high phase the slave drives 24 bits: a flag (0 for valid), A6..A0, then D15..D0. It changes the data line only after falling bus clock edges.
- R8: An address at or above NUM_REGS, or a read answered with reg_hit low, returns flag 1 and all-zero data. Out-of-range addresses never produce reg_rd or reg_wr.
- R9: Each prepare serves one read only. A code 2'b11 with no pending prepare, and the codes 2'b00 and 2'b01, cause no drive and no register access.
- R10: l3_data_oe stays low during select bytes, during bytes the master sends, and after the 24th bit of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 2 | Strapped low bits of the device identity |
| l3_clk_i | input | 1 | Bus bit clock, asynchronous |
| l3_mode_i | input | 1 | Bus mode line: low selects, high transfers |
| l3_data_i | input | 1 | Bus data from the master |
| l3_data_o | output | 1 | Bus data to the master during reads |
| l3_data_oe | output | 1 | High while the slave drives the data line |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_rd | output | 1 | Register read strobe, one cycle |
| reg_addr | output | 7 | Register address for either strobe |
| reg_wdata | output | 16 | Write value |
| reg_rdata | input | 16 | Read value, valid the cycle after reg_rd |
| reg_hit | input | 1 | Register exists, valid with reg_rdata |

## Verification
Several properties are checked on every cycle. Strobes never fall outside the register range and never overlap. Each write strobe lasts one cycle. The returned data bit moves only after a falling bus clock edge. Nothing is driven before the wake pulse. Other behaviour only shows up over whole transactions, so the bench's scenarios must cover it. That includes the bit ordering of select, register and data bytes, identity matching, discarding of short bytes and of trailing bytes, the one-shot use of a prepare, and the flag and zeroed data returned for a missing register.

// File: rtl/l3s_pkg.sv
package l3s_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 1 + ADDR_W + DATA_W;

    localparam logic [1:0] CODE_WRITE = 2'b10;
    localparam logic [1:0] CODE_READ  = 2'b11;
    localparam logic [3:0] ID_FIXED   = 4'b0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_REG,
        ST_WR_HI,
        ST_WR_LO,
        ST_HOLD,
        ST_RD_WAIT,
        ST_RD_TAKE,
        ST_RD_SEND
    } l3s_state_e;
endpackage

// File: rtl/l3s_sync.sv
module l3s_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.pipe[s] = sync_q.pipe[s-1];
        end
        sync_d.last = sync_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q.pipe[STAGES-1];

    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise_o[b] = sync_q.pipe[STAGES-1][b] & ~sync_q.last[b];
        assign fall_o[b] = ~sync_q.pipe[STAGES-1][b] & sync_q.last[b];
    end
endmodule

// File: rtl/l3s_rx.sv
module l3s_rx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_rise,
    input  logic            mode_edge,
    input  logic            din,
    input  logic            enable,
    output logic            byte_done_o,
    output logic [BITS-1:0] lsb_first_o,
    output logic [BITS-1:0] msb_first_o,
    output logic            awake_o
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    typedef struct packed {
        logic            awake;
        logic [CW-1:0]   cnt;
        logic [BITS-1:0] sh_l;
        logic [BITS-1:0] sh_m;
        logic            done;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (mode_edge) begin
            rx_d.cnt = '0;
        end else if (sclk_rise) begin
            if (!rx_q.awake) begin
                rx_d.awake = 1'b1;
            end else if (enable) begin
                rx_d.sh_l = {din, rx_q.sh_l[BITS-1:1]};
                rx_d.sh_m = {rx_q.sh_m[BITS-2:0], din};
                if (rx_q.cnt == LAST) begin
                    rx_d.cnt  = '0;
                    rx_d.done = 1'b1;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign byte_done_o = rx_q.done;
    assign lsb_first_o = rx_q.sh_l;
    assign msb_first_o = rx_q.sh_m;
    assign awake_o     = rx_q.awake;
endmodule

// File: rtl/l3s_tx.sv
module l3s_tx #(
    parameter int LEN = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] load_word,
    input  logic           sclk_rise,
    input  logic           sclk_fall,
    input  logic           mode_hi,
    input  logic           mode_fall,
    output logic           dout,
    output logic           oe
);
    localparam int CW = $clog2(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic           active;
        logic [LEN-1:0] word;
        logic [CW-1:0]  cnt;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.active = 1'b1;
            tx_d.word   = load_word;
            tx_d.cnt    = '0;
        end else if (tx_q.active) begin
            if (mode_fall) begin
                tx_d.active = 1'b0;
            end else if (mode_hi) begin
                if (sclk_fall) tx_d.word = {tx_q.word[LEN-2:0], 1'b0};
                if (sclk_rise) begin
                    if (tx_q.cnt == LAST) tx_d.active = 1'b0;
                    else                  tx_d.cnt    = tx_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign dout = tx_q.word[LEN-1];
    assign oe   = tx_q.active & mode_hi;
endmodule

// File: rtl/l3s_ctrl.sv
module l3s_ctrl
    import l3s_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dev_sel,
    input  logic              mode_hi,
    input  logic              mode_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] lsb_byte,
    input  logic [BYTE_W-1:0] msb_byte,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_hit,
    output logic              rx_en,
    output logic              tx_load,
    output logic [WORD_W-1:0] tx_word,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    typedef struct packed {
        l3s_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] hi;
        logic              prep;
        logic [ADDR_W-1:0] prep_addr;
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] wdata;
        logic              load;
        logic [WORD_W-1:0] word;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic [5:0] own_id;
    assign own_id = {ID_FIXED, dev_sel};

    function automatic logic in_range(input logic [ADDR_W-1:0] a);
        return ({{(32-ADDR_W){1'b0}}, a} < 32'(NUM_REGS));
    endfunction

    always_comb begin
        c_d      = c_q;
        c_d.wr   = 1'b0;
        c_d.rd   = 1'b0;
        c_d.load = 1'b0;
        if (mode_fall) begin
            c_d.state = ST_IDLE;
        end else begin
            case (c_q.state)
                ST_RD_WAIT: c_d.state = ST_RD_TAKE;
                ST_RD_TAKE: begin
                    c_d.load  = 1'b1;
                    c_d.word  = {~reg_hit, c_q.addr, reg_hit ? reg_rdata : '0};
                    c_d.state = ST_RD_SEND;
                end
                ST_RD_SEND: ;
                default: begin
                    if (byte_done && !mode_hi) begin
                        c_d.state = ST_IDLE;
                        if (lsb_byte[7:2] == own_id) begin
                            if (lsb_byte[1:0] == CODE_WRITE) begin
                                c_d.state = ST_WR_REG;
                            end else if (lsb_byte[1:0] == CODE_READ && c_q.prep) begin
                                c_d.prep = 1'b0;
                                if (in_range(c_q.prep_addr)) begin
                                    c_d.rd    = 1'b1;
                                    c_d.addr  = c_q.prep_addr;
                                    c_d.state = ST_RD_WAIT;
                                end else begin
                                    c_d.load  = 1'b1;
                                    c_d.word  = {1'b1, c_q.prep_addr, {DATA_W{1'b0}}};
                                    c_d.state = ST_RD_SEND;
                                end
                            end
                        end
                    end else if (byte_done) begin
                        case (c_q.state)
                            ST_WR_REG: begin
                                if (!msb_byte[7]) begin
                                    c_d.addr  = msb_byte[ADDR_W-1:0];
                                    c_d.state = ST_WR_HI;
                                end else begin
                                    c_d.prep      = 1'b1;
                                    c_d.prep_addr = msb_byte[ADDR_W-1:0];
                                    c_d.state     = ST_HOLD;
                                end
                            end
                            ST_WR_HI: begin
                                c_d.hi    = msb_byte;
                                c_d.state = ST_WR_LO;
                            end
                            ST_WR_LO: begin
                                if (in_range(c_q.addr)) begin
                                    c_d.wr    = 1'b1;
                                    c_d.wdata = {c_q.hi, msb_byte};
                                end
                                c_d.state = ST_HOLD;
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign rx_en     = !(c_q.state inside {ST_RD_WAIT, ST_RD_TAKE, ST_RD_SEND});
    assign tx_load   = c_q.load;
    assign tx_word   = c_q.word;
    assign reg_wr    = c_q.wr;
    assign reg_rd    = c_q.rd;
    assign reg_addr  = c_q.addr;
    assign reg_wdata = c_q.wdata;
endmodule

// File: rtl/l3_slave.sv
module l3_slave
    import l3s_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dev_sel,
    input  logic              l3_clk_i,
    input  logic              l3_mode_i,
    input  logic              l3_data_i,
    output logic              l3_data_o,
    output logic              l3_data_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_hit
);
    localparam int PIN_CLK  = 0;
    localparam int PIN_MODE = 1;
    localparam int PIN_DATA = 2;

    logic [2:0]        pin_lvl, pin_rise, pin_fall;
    logic              sclk_rise, sclk_fall, mode_hi, mode_fall, mode_edge;
    logic              byte_done, rx_en, awake, tx_load;
    logic [BYTE_W-1:0] lsb_byte, msb_byte;
    logic [WORD_W-1:0] tx_word;

    l3s_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({l3_data_i, l3_mode_i, l3_clk_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign sclk_rise = pin_rise[PIN_CLK];
    assign sclk_fall = pin_fall[PIN_CLK];
    assign mode_hi   = pin_lvl[PIN_MODE];
    assign mode_fall = pin_fall[PIN_MODE];
    assign mode_edge = pin_rise[PIN_MODE] | pin_fall[PIN_MODE];

    l3s_rx #(.BITS(BYTE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .mode_edge   (mode_edge),
        .din         (pin_lvl[PIN_DATA]),
        .enable      (rx_en),
        .byte_done_o (byte_done),
        .lsb_first_o (lsb_byte),
        .msb_first_o (msb_byte),
        .awake_o     (awake)
    );

    l3s_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_sel   (dev_sel),
        .mode_hi   (mode_hi),
        .mode_fall (mode_fall),
        .byte_done (byte_done),
        .lsb_byte  (lsb_byte),
        .msb_byte  (msb_byte),
        .reg_rdata (reg_rdata),
        .reg_hit   (reg_hit),
        .rx_en     (rx_en),
        .tx_load   (tx_load),
        .tx_word   (tx_word),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    l3s_tx #(.LEN(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_word (tx_word),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mode_hi   (mode_hi),
        .mode_fall (mode_fall),
        .dout      (l3_data_o),
        .oe        (l3_data_oe)
    );
endmodule

// File: rtl/l3s_checker.sv
module l3s_checker #(
    parameter int NUM_REGS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [6:0] reg_addr,
    input logic       l3_data_o,
    input logic       l3_data_oe,
    input logic       sclk_fall,
    input logic       awake
);
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ({25'd0, reg_addr} < 32'(NUM_REGS))); // R8
    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> ({25'd0, reg_addr} < 32'(NUM_REGS))); // R8
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R3
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd})); // R3
    AST_DOUT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (l3_data_oe && $past(l3_data_oe) && !$stable(l3_data_o)) |-> $past(sclk_fall)); // R7
    AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |-> !l3_data_oe); // R1
endmodule

bind l3_slave l3s_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .l3_data_o  (l3_data_o),
    .l3_data_oe (l3_data_oe),
    .sclk_fall  (sclk_fall),
    .awake      (awake)
);

// File: tb/tb_l3_slave.sv
module tb_l3_slave;
    localparam int HALF = 8;
    localparam logic [7:0] SEL_WR  = 8'h1A;
    localparam logic [7:0] SEL_RD  = 8'h1B;
    localparam logic [7:0] SEL_BAD = 8'h16;
    localparam logic [7:0] SEL_C01 = 8'h19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l3_clk = 1'b0, l3_mode = 1'b0, l3_data = 1'b0;
    logic        l3_data_o, l3_data_oe, reg_wr, reg_rd, hit_q;
    logic [6:0]  reg_addr;
    logic [15:0] reg_wdata, rdata_q;
    logic [15:0] bank [16];
    int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, quiet_err = 0;

    always #5 clk = ~clk;

    l3_slave dut (
        .clk(clk), .rst_n(rst_n), .dev_sel(2'b10),
        .l3_clk_i(l3_clk), .l3_mode_i(l3_mode), .l3_data_i(l3_data),
        .l3_data_o(l3_data_o), .l3_data_oe(l3_data_oe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_q), .reg_hit(hit_q)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bank[i] <= '0;
            rdata_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                wr_cnt <= wr_cnt + 1;
                if (reg_addr < 7'd16) bank[reg_addr[3:0]] <= reg_wdata;
            end
            if (reg_rd) rd_cnt <= rd_cnt + 1;
            rdata_q <= bank[reg_addr[3:0]];
            hit_q   <= (reg_addr < 7'd16) && (reg_addr != 7'd5);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic l3_bit(input logic b);
        l3_data = b;
        repeat (HALF) @(negedge clk);
        if (l3_data_oe) quiet_err++;
        l3_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        l3_clk = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        l3_mode = m;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_sel(input logic [7:0] b, input int nbits);
        set_mode(1'b0);
        for (int i = 0; i < nbits; i++) l3_bit(b[i]);
        set_mode(1'b1);
    endtask

    task automatic send_byte(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) l3_bit(b[7-i]);
        repeat (4) @(negedge clk);
    endtask

    task automatic recv_byte(output logic [7:0] b, output int oe_bits);
        b = '0;
        oe_bits = 0;
        l3_data = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (HALF) @(negedge clk);
            if (l3_data_oe) oe_bits++;
            b[7-i] = l3_data_o;
            l3_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            l3_clk = 1'b0;
        end
    endtask

    task automatic write_reg(input logic [7:0] sel, input logic [6:0] r, input logic [15:0] v);
        send_sel(sel, 8);
        send_byte({1'b0, r}, 8);
        send_byte(v[15:8], 8);
        send_byte(v[7:0], 8);
    endtask

    task automatic prepare(input logic [6:0] r);
        send_sel(SEL_WR, 8);
        send_byte({1'b1, r}, 8);
    endtask

    task automatic read_expect(input string req, input logic [7:0] e0, input logic [7:0] e1,
                               input logic [7:0] e2);
        logic [7:0] b0, b1, b2;
        int o0, o1, o2;
        send_sel(SEL_RD, 8);
        recv_byte(b0, o0);
        recv_byte(b1, o1);
        recv_byte(b2, o2);
        check({req, " flag+addr"}, 32'(b0), 32'(e0));
        check({req, " data hi"}, 32'(b1), 32'(e1));
        check({req, " data lo"}, 32'(b2), 32'(e2));
        check({req, " driven bits"}, 32'(o0 + o1 + o2), 32'd24);
        repeat (4) @(negedge clk);
        check("R10 released after read", 32'(l3_data_oe), 32'd0);
    endtask

    task automatic t_reset;
        check("R10 oe at reset", 32'(l3_data_oe), 32'd0);
        check("R3 no write at reset", 32'(reg_wr), 32'd0);
        check("R7 no read at reset", 32'(reg_rd), 32'd0);
    endtask

    task automatic t_wake;
        write_reg(SEL_WR, 7'd3, 16'h1111);
        check("R1 no write before wake", 32'(wr_cnt), 32'd0);
        check("R1 reg3 untouched", 32'(bank[3]), 32'd0);
    endtask

    task automatic t_write;
        write_reg(SEL_WR, 7'd3, 16'hA55A);
        check("R3 write count", 32'(wr_cnt), 32'd1);
        check("R3 reg3 value", 32'(bank[3]), 32'hA55A);
        write_reg(SEL_BAD, 7'd3, 16'h0F0F);
        check("R2 foreign identity ignored", 32'(bank[3]), 32'hA55A);
        write_reg(SEL_C01, 7'd3, 16'h0F0F);
        check("R9 code 01 ignored", 32'(wr_cnt), 32'd1);
    endtask

    task automatic t_trailing;
        write_reg(SEL_WR, 7'd7, 16'hBEEF);
        send_byte(8'h11, 8);
        send_byte(8'h22, 8);
        check("R4 one write only", 32'(wr_cnt), 32'd2);
        check("R4 reg7 kept", 32'(bank[7]), 32'hBEEF);
    endtask

    task automatic t_partial;
        send_sel(SEL_WR, 5);
        send_byte(8'h04, 8);
        send_byte(8'h12, 8);
        send_byte(8'h34, 8);
        check("R5 short select discarded", 32'(wr_cnt), 32'd2);
        send_sel(SEL_WR, 8);
        send_byte(8'h04, 8);
        send_byte(8'h12, 8);
        send_byte(8'h34, 5);
        set_mode(1'b0);
        repeat (4) @(negedge clk);
        check("R5 short data byte discarded", 32'(bank[4]), 32'd0);
        write_reg(SEL_WR, 7'd4, 16'h1234);
        check("R5 counter restarted", 32'(bank[4]), 32'h1234);
    endtask

    task automatic t_read;
        prepare(7'd3);
        check("R6 prepare no read", 32'(rd_cnt), 32'd0);
        check("R6 prepare no write", 32'(wr_cnt), 32'd3);
        read_expect("R7", 8'h03, 8'hA5, 8'h5A);
        check("R7 one read strobe", 32'(rd_cnt), 32'd1);
    endtask

    task automatic t_invalid;
        prepare(7'd5);
        read_expect("R8 missing reg", 8'h85, 8'h00, 8'h00);
        prepare(7'd20);
        read_expect("R8 out of range", 8'h94, 8'h00, 8'h00);
        check("R8 no strobe out of range", 32'(rd_cnt), 32'd2);
        write_reg(SEL_WR, 7'd20, 16'h5555);
        check("R8 no write out of range", 32'(wr_cnt), 32'd3);
    endtask

    task automatic t_no_prepare;
        logic [7:0] b;
        int ob;
        send_sel(SEL_RD, 8);
        recv_byte(b, ob);
        check("R9 no drive without prepare", 32'(ob), 32'd0);
        check("R9 no read strobe", 32'(rd_cnt), 32'd2);
        check("R10 quiet while master sends", 32'(quiet_err), 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_wake();
        t_write();
        t_trailing();
        t_partial();
        t_read();
        t_invalid();
        t_no_prepare();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule